// File: doc/BRIEF.md
# Secure Boot Sequencing Controller

This controller drives a system through its first boot stage after every power-on or warm reset. It decodes the boot mode straps to choose a source, and reads one header word from that source over a valid/ready port. From the header it decides whether the image is encrypted, must stay within the on-chip size limit, or runs in place from flash. It then starts the image mover and routes the data either through the decrypt/authenticate path or through the internal loopback. When the move completes it releases the CPU to the first-stage loader. The flash drivers, the crypto engines and the data mover are outside the block. The block sees them only as handshakes.

Security rules shape the sequence. The debug port stays shut while stage 0 runs. An encrypted image is only moved once programmable-logic power is confirmed. Running in place turns every secure feature off. A first stage that booted without security sets a sticky lock, and only a reset clears it. In debug-port slave mode an external host loads the image while the CPU is held idle. The controller releases the CPU once the host signals that the load is complete. A bad strap code, a missing power flag or an oversized image sends the block to a lockdown state, which lasts until reset.

The header port follows valid/ready rules. The source may raise `hdr_valid` at any time and must hold `hdr_data` stable until the word is taken. The controller raises `hdr_ready` only while it waits for the header. A word is taken on the first rising edge where both signals are high. Exactly one word is taken per boot.

Top module: `boot_sequencer`

## Requirements
- R1: Strap codes select the source: 3'b000 debug-port slave, 3'b001 quad-SPI, 3'b010 NAND, 3'b011 NOR, 3'b100 SD. The chosen code appears on `boot_src`. Codes 3'b101 to 3'b111 give lockdown with `err_code` 2'd1.
- R2: `jtag_en` is low from reset through the whole stage-0 sequence and in lockdown. It is high only while waiting for an external load, or after release of a non-secure boot.
- R3: In master modes the header is taken through `hdr_valid`/`hdr_ready`, and `hdr_ready` is high only while the header is awaited. Header bit 31 means encrypted, bit 30 means execute-in-place, and bits 19:0 give the image length in bytes. Exactly one word is accepted per boot.
- R4: An encrypted image (not in place) with `pl_pwr_good` low at the check cycle gives lockdown with `err_code` 2'd2, and no `dma_start`.
- R5: `dma_start` is a one-cycle pulse. `dma_route` is 1 (decrypt path) for a secure image and 0 (loopback) for a plaintext one.
- R6: A length above 196608 without execute-in-place gives lockdown with `err_code` 2'd3. A length of exactly 196608 is accepted. With execute-in-place, any length is accepted.
- R7: Execute-in-place drops security. An encrypted, in-place image uses route 0, needs no power flag, and ends with `boot_secure` low.
- R8: `cpu_release` is a single-cycle pulse. It is issued only after `dma_done`, or after `jtag_load_done` in slave mode, and at most once per boot.
- R9: `sec_lock` is set when a non-secure boot releases the CPU. It stays set until `rst_n` or `warm_rst`.
- R10: Lockdown holds its error code and ignores `dma_done`, `jtag_load_done` and `pl_pwr_good` until reset.
- R11: In slave mode, no header is read and no transfer is started. `jtag_en` opens while the CPU is idle, and the boot is always non-secure.
- R12: `warm_rst` restarts the sequence from strap decode in the next cycle and takes priority over any handshake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| strap | input | 3 | Boot mode strap pins |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Controller ready for the header word |
| hdr_data | input | 32 | Header word |
| pl_pwr_good | input | 1 | Programmable-logic power is up |
| dma_start | output | 1 | Start pulse to the image mover |
| dma_route | output | 1 | 1: decrypt path, 0: internal loopback |
| dma_done | input | 1 | Image mover finished |
| jtag_load_done | input | 1 | External host finished loading (slave mode) |
| jtag_en | output | 1 | Debug port access gate |
| cpu_release | output | 1 | One-cycle CPU release pulse |
| boot_src | output | 3 | Decoded boot source code |
| boot_secure | output | 1 | Current boot runs secure |
| sec_lock | output | 1 | Sticky: later stages restricted to non-secure |
| err_code | output | 2 | 0 none, 1 bad strap, 2 no PL power, 3 image too long |

## Verification
Two events can land on the same edge. One is the completion handshake of the image mover, which would release the CPU. The other is a warm reset, which must restart the sequence. The bench drives `dma_done` and `warm_rst` high in the same cycle while a plaintext transfer is pending. It then checks that no release pulse appears, that the sticky lock stays clear, and that the controller goes back to waiting for a fresh header.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;
  typedef enum logic [2:0] {
    SRC_DBG  = 3'd0,
    SRC_QSPI = 3'd1,
    SRC_NAND = 3'd2,
    SRC_NOR  = 3'd3,
    SRC_SD   = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_STRAP = 2'd1,
    ERR_NOPWR = 2'd2,
    ERR_LEN   = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_DECODE,
    ST_HDR,
    ST_CHECK,
    ST_XFER,
    ST_WAIT,
    ST_EXTWAIT,
    ST_REL,
    ST_RUN,
    ST_LOCK
  } st_e;
endpackage

// File: rtl/bootseq_strap_dec.sv
module bootseq_strap_dec
  import bootseq_pkg::*;
(
  input  logic [2:0] strap,
  output logic       known,
  output logic       slave
);
  always_comb begin
    known = 1'b1;
    slave = 1'b0;
    case (strap)
      SRC_DBG:                          slave = 1'b1;
      SRC_QSPI, SRC_NAND, SRC_NOR, SRC_SD: slave = 1'b0;
      default:                          known = 1'b0;
    endcase
  end
endmodule

// File: rtl/bootseq_hdr_eval.sv
module bootseq_hdr_eval #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 20,
  parameter int MAX_LEN = 196608,
  parameter int ENC_BIT = 31,
  parameter int XIP_BIT = 30
) (
  input  logic [DATA_W-1:0] hdr,
  output logic              secure,
  output logic              len_ok
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);
  logic enc, xip;
  logic [LEN_W-1:0] len;
  assign enc    = hdr[ENC_BIT];
  assign xip    = hdr[XIP_BIT];
  assign len    = hdr[LEN_W-1:0];
  assign secure = enc & ~xip;
  assign len_ok = xip | (len <= LIMIT);
endmodule

// File: rtl/bootseq_fsm.sv
module bootseq_fsm
  import bootseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [2:0]        strap,
  input  logic              strap_known,
  input  logic              strap_slave,
  input  logic              hdr_valid,
  input  logic [DATA_W-1:0] hdr_data,
  output logic [DATA_W-1:0] hdr_q,
  input  logic              img_secure,
  input  logic              img_len_ok,
  input  logic              pl_pwr_good,
  input  logic              dma_done,
  input  logic              jtag_load_done,
  output logic              hdr_ready,
  output logic              dma_start,
  output logic              dma_route,
  output logic              jtag_en,
  output logic              cpu_release,
  output logic [2:0]        boot_src,
  output logic              boot_secure,
  output logic              sec_lock,
  output logic [1:0]        err_code
);
  st_e  state, nxt;
  err_e err_q, err_d;
  logic secure_q, secure_d;
  logic lock_q;
  logic [2:0] src_q;

  always_comb begin
    nxt      = state;
    err_d    = err_q;
    secure_d = secure_q;
    unique case (state)
      ST_DECODE: begin
        if (!strap_known) begin
          nxt   = ST_LOCK;
          err_d = ERR_STRAP;
        end else if (strap_slave) begin
          nxt = ST_EXTWAIT;
        end else begin
          nxt = ST_HDR;
        end
      end
      ST_HDR:     if (hdr_valid) nxt = ST_CHECK;
      ST_CHECK: begin
        if (!img_len_ok) begin
          nxt   = ST_LOCK;
          err_d = ERR_LEN;
        end else if (img_secure && !pl_pwr_good) begin
          nxt   = ST_LOCK;
          err_d = ERR_NOPWR;
        end else begin
          nxt      = ST_XFER;
          secure_d = img_secure;
        end
      end
      ST_XFER:    nxt = ST_WAIT;
      ST_WAIT:    if (dma_done) nxt = ST_REL;
      ST_EXTWAIT: if (jtag_load_done) nxt = ST_REL;
      ST_REL:     nxt = ST_RUN;
      ST_RUN:     nxt = ST_RUN;
      ST_LOCK:    nxt = ST_LOCK;
      default:    nxt = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_DECODE;
      err_q    <= ERR_NONE;
      secure_q <= 1'b0;
      lock_q   <= 1'b0;
      src_q    <= '0;
      hdr_q    <= '0;
    end else if (warm_rst) begin
      state    <= ST_DECODE;
      err_q    <= ERR_NONE;
      secure_q <= 1'b0;
      lock_q   <= 1'b0;
      src_q    <= '0;
      hdr_q    <= '0;
    end else begin
      state    <= nxt;
      err_q    <= err_d;
      secure_q <= secure_d;
      if (state == ST_DECODE) src_q <= strap;
      if (state == ST_HDR && hdr_valid) hdr_q <= hdr_data;
      if (state == ST_REL && !secure_q) lock_q <= 1'b1;
    end
  end

  assign hdr_ready   = (state == ST_HDR);
  assign dma_start   = (state == ST_XFER);
  assign dma_route   = secure_q;
  assign cpu_release = (state == ST_REL);
  assign jtag_en     = (state == ST_EXTWAIT) || (state == ST_RUN && !secure_q);
  assign boot_src    = src_q;
  assign boot_secure = secure_q;
  assign sec_lock    = lock_q;
  assign err_code    = err_q;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 20,
  parameter int MAX_LEN = 196608,
  parameter int ENC_BIT = 31,
  parameter int XIP_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [2:0]        strap,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [DATA_W-1:0] hdr_data,
  input  logic              pl_pwr_good,
  output logic              dma_start,
  output logic              dma_route,
  input  logic              dma_done,
  input  logic              jtag_load_done,
  output logic              jtag_en,
  output logic              cpu_release,
  output logic [2:0]        boot_src,
  output logic              boot_secure,
  output logic              sec_lock,
  output logic [1:0]        err_code
);
  logic known, slave, img_secure, img_len_ok;
  logic [DATA_W-1:0] hdr_q;

  bootseq_strap_dec u_dec (
    .strap (strap),
    .known (known),
    .slave (slave)
  );

  bootseq_hdr_eval #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_LEN),
    .ENC_BIT(ENC_BIT),
    .XIP_BIT(XIP_BIT)
  ) u_eval (
    .hdr   (hdr_q),
    .secure(img_secure),
    .len_ok(img_len_ok)
  );

  bootseq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .warm_rst      (warm_rst),
    .strap         (strap),
    .strap_known   (known),
    .strap_slave   (slave),
    .hdr_valid     (hdr_valid),
    .hdr_data      (hdr_data),
    .hdr_q         (hdr_q),
    .img_secure    (img_secure),
    .img_len_ok    (img_len_ok),
    .pl_pwr_good   (pl_pwr_good),
    .dma_done      (dma_done),
    .jtag_load_done(jtag_load_done),
    .hdr_ready     (hdr_ready),
    .dma_start     (dma_start),
    .dma_route     (dma_route),
    .jtag_en       (jtag_en),
    .cpu_release   (cpu_release),
    .boot_src      (boot_src),
    .boot_secure   (boot_secure),
    .sec_lock      (sec_lock),
    .err_code      (err_code)
  );
endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       warm_rst,
  input logic       hdr_ready,
  input logic       pl_pwr_good,
  input logic       dma_start,
  input logic       dma_route,
  input logic       jtag_en,
  input logic       cpu_release,
  input logic       sec_lock,
  input logic [1:0] err_code
);
  AST_DBG_CLOSED_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    (err_code != 2'd0) |-> (!jtag_en && !hdr_ready)); // R2
  AST_HDR_ALONE: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    hdr_ready |-> (!jtag_en && !dma_start && !cpu_release)); // R3
  AST_PWR_BEFORE_DECRYPT: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    (dma_start && dma_route) |-> $past(pl_pwr_good)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    dma_start |=> !dma_start); // R5
  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    cpu_release |=> !cpu_release); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    sec_lock |=> sec_lock); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || warm_rst)
    (err_code != 2'd0) |=> $stable(err_code)); // R10
endmodule

bind boot_sequencer boot_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .warm_rst   (warm_rst),
  .hdr_ready  (hdr_ready),
  .pl_pwr_good(pl_pwr_good),
  .dma_start  (dma_start),
  .dma_route  (dma_route),
  .jtag_en    (jtag_en),
  .cpu_release(cpu_release),
  .sec_lock   (sec_lock),
  .err_code   (err_code)
);

// File: tb/boot_sequencer_test.sv
`timescale 1ns/1ps
module boot_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, warm_rst = 1'b0;
  logic [2:0] strap = 3'd1;
  logic hdr_valid = 1'b0;
  logic [31:0] hdr_data = '0;
  logic pl_pwr_good = 1'b0, dma_done = 1'b0, jtag_load_done = 1'b0;
  logic hdr_ready, dma_start, dma_route, jtag_en, cpu_release, boot_secure, sec_lock;
  logic [2:0] boot_src;
  logic [1:0] err_code;

  int vectors = 0, fails = 0, cycles = 0;
  int dma_cnt = 0, rel_cnt = 0, hs_cnt = 0;
  logic route_seen = 1'b0;

  always #4 clk = ~clk;

  boot_sequencer uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .strap(strap),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .pl_pwr_good(pl_pwr_good), .dma_start(dma_start), .dma_route(dma_route),
    .dma_done(dma_done), .jtag_load_done(jtag_load_done), .jtag_en(jtag_en),
    .cpu_release(cpu_release), .boot_src(boot_src), .boot_secure(boot_secure),
    .sec_lock(sec_lock), .err_code(err_code)
  );

  always @(negedge clk) begin
    if (!rst_n || warm_rst) begin
      dma_cnt = 0; rel_cnt = 0; hs_cnt = 0;
    end else begin
      if (dma_start) begin dma_cnt++; route_seen = dma_route; end
      if (cpu_release) rel_cnt++;
      if (hdr_valid && hdr_ready) hs_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s, input logic pwr);
    @(negedge clk);
    rst_n = 1'b0; strap = s; pl_pwr_good = pwr;
    hdr_valid = 1'b0; dma_done = 1'b0; jtag_load_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20 && !hdr_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(3'd1, 1'b0);
    chk("R2 jtag low in stage0", jtag_en, 0);
    chk("R3 ready low at decode", hdr_ready, 0);
    chk("R8 no release at reset", cpu_release, 0);
    chk("R10 no error at reset", err_code, 0);
    chk("R9 lock clear at reset", sec_lock, 0);
  endtask

  task automatic t_flash(input logic [2:0] s, input logic [31:0] hdr, input logic pwr,
                         input logic [1:0] exp_err, input logic exp_sec);
    do_reset(s, pwr);
    wait_ready();
    chk("R3 header awaited", hdr_ready, 1);
    chk("R2 jtag low while header awaited", jtag_en, 0);
    chk("R1 source code", boot_src, s);
    hdr_data = hdr; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R3 one header word", hs_cnt, 1);
    if (exp_err != 2'd0) begin
      repeat (4) @(negedge clk);
      chk("R6/R4 lockdown code", err_code, exp_err);
      chk("R4 no transfer in lockdown", dma_cnt, 0);
      chk("R2 jtag low in lockdown", jtag_en, 0);
      dma_done = 1'b1; jtag_load_done = 1'b1; pl_pwr_good = ~pl_pwr_good;
      repeat (3) @(negedge clk);
      dma_done = 1'b0; jtag_load_done = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 code held", err_code, exp_err);
      chk("R10 no release", rel_cnt, 0);
    end else begin
      for (int i = 0; i < 10 && dma_cnt == 0; i++) @(negedge clk);
      chk("R5 one start pulse", dma_cnt, 1);
      chk("R5/R7 route", route_seen, exp_sec);
      repeat (3) @(negedge clk);
      chk("R5 start not repeated", dma_cnt, 1);
      chk("R8 no release before done", rel_cnt, 0);
      dma_done = 1'b1;
      @(negedge clk);
      dma_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 one release", rel_cnt, 1);
      chk("R7 secure flag", boot_secure, exp_sec);
      chk("R2 jtag after release", jtag_en, !exp_sec);
      chk("R9 lock after release", sec_lock, !exp_sec);
      chk("R10 no error", err_code, 0);
    end
  endtask

  task automatic t_bad_strap(input logic [2:0] s);
    do_reset(s, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 bad strap code", err_code, 1);
    chk("R3 no header read on bad strap", hdr_ready, 0);
    chk("R2 jtag low on bad strap", jtag_en, 0);
  endtask

  task automatic t_slave();
    do_reset(3'd0, 1'b0);
    chk("R2 jtag low at decode", jtag_en, 0);
    for (int i = 0; i < 10 && !jtag_en; i++) @(negedge clk);
    chk("R11 jtag open for host", jtag_en, 1);
    hdr_valid = 1'b1;
    repeat (3) @(negedge clk);
    hdr_valid = 1'b0;
    chk("R11 no header taken", hs_cnt, 0);
    chk("R11 no transfer", dma_cnt, 0);
    chk("R8 held idle", rel_cnt, 0);
    jtag_load_done = 1'b1;
    @(negedge clk);
    jtag_load_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 release after host load", rel_cnt, 1);
    chk("R11 non-secure", boot_secure, 0);
    chk("R9 lock set by slave boot", sec_lock, 1);
    repeat (20) @(negedge clk);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk("R9 lock stays", sec_lock, 1);
    chk("R8 at most one release", rel_cnt, 1);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    chk("R9 warm reset clears lock", sec_lock, 0);
    chk("R12 jtag low after warm reset", jtag_en, 0);
  endtask

  task automatic t_warm_race();
    do_reset(3'd2, 1'b1);
    wait_ready();
    hdr_data = 32'h0000_2000; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < 10 && dma_cnt == 0; i++) @(negedge clk);
    dma_done = 1'b1; warm_rst = 1'b1;
    @(negedge clk);
    dma_done = 1'b0; warm_rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 warm reset beats done", rel_cnt, 0);
    chk("R12 lock stays clear", sec_lock, 0);
    wait_ready();
    chk("R12 header awaited again", hdr_ready, 1);
  endtask

  initial begin
    t_reset_state();
    t_flash(3'd1, 32'h0000_1000, 1'b0, 2'd0, 1'b0);
    t_flash(3'd2, 32'h8003_0000, 1'b1, 2'd0, 1'b1);
    t_flash(3'd3, 32'h8000_0100, 1'b0, 2'd2, 1'b0);
    t_flash(3'd4, 32'h0003_0001, 1'b1, 2'd3, 1'b0);
    t_flash(3'd1, 32'hC00F_FFFF, 1'b0, 2'd0, 1'b0);
    t_bad_strap(3'd5);
    t_bad_strap(3'd7);
    t_slave();
    t_warm_race();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule